// File: doc/BRIEF.md
# Split Read/Write Interrupt Register

This block gathers five interrupt events of a home-computer gate array into one byte-wide register on an 8-bit CPU bus. A write to the register loads an enable mask that software can never read back. A read of the same location shows which events are pending, whether or not they are enabled. It also shows a power-on flag and a summary bit that mirrors the interrupt line. An active-low IRQ output goes to the CPU.

Each event input is a one-cycle pulse that sets a sticky pending flag. Three flags are cleared by writing ones to a separate clear register. The other two are cleared as side effects of accessing the serial data register: a read clears receive-full and a write clears transmit-empty. The block receives those accesses as strobes; the video and serial logic that raise the events lies outside it.

Top module: `split_irq_ctrl`

## Requirements
- R1: A write strobe (`irq_wr_i`) loads `wdata_i[6:2]` as the enables. Bits 7, 1 and 0 of the written byte have no effect.
- R2: Read bits 6:2 show the raw pending flags, whether or not each one is enabled. The mapping is bit 2 display end (`evt_i[0]`), bit 3 real-time clock (`evt_i[1]`), bit 4 receive full (`evt_i[2]`), bit 5 transmit empty (`evt_i[3]`) and bit 6 high tone (`evt_i[4]`). A flag set by a one-cycle pulse stays set until it is cleared, and it is visible on `rdata_o` after the clock edge that samples the pulse.
- R3: Read bit 0 is the master interrupt: the OR, over bits 6:2, of each pending flag ANDed with its enable.
- R4: Read bit 7 is always 1. Read bit 1 is a power-on flag: reset sets it, and it clears after the first read strobe (`irq_rd_i`).
- R5: `irq_no` is low exactly when read bit 0 is 1.
- R6: A clear-register write (`clr_wr_i`) clears the flags at bits 2, 3 and 6 wherever `wdata_i` holds a 1 in the same position. Bits 4 and 5 of that write do not touch the receive-full or transmit-empty flags.
- R7: A serial-data read strobe (`ser_rd_i`) clears the receive-full flag. A serial-data write strobe (`ser_wr_i`) clears the transmit-empty flag.
- R8: When an event pulse and a clear for the same flag arrive in the same cycle, the flag ends up set.
- R9: Reset clears all enables and all pending flags, so `irq_no` is high after reset. A later event is then pending but does not interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_wr_i | input | 1 | Write strobe for the enable mask |
| irq_rd_i | input | 1 | Read strobe of the interrupt register |
| clr_wr_i | input | 1 | Write strobe of the clear register |
| wdata_i | input | 8 | CPU write data |
| ser_rd_i | input | 1 | Serial data register read strobe |
| ser_wr_i | input | 1 | Serial data register write strobe |
| evt_i | input | 5 | Event pulses, bit k sets the flag at read bit k+2 |
| rdata_o | output | 8 | Register read value |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its package defaults: five sources starting at bit 2 of an 8-bit bus. With these values every source position, each of the three clearing mechanisms and the ignored mask bits (7, 1, 0) can be driven directly. The bench pairs enable masks with event patterns to show that pending flags are visible while masked and that only enabled pairs drive the IRQ line. Directed cases cover the power-on flag's single-read life, same-cycle set against clear, and a reset in the middle of a run.

// File: rtl/split_irq_pkg.sv
package split_irq_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned SRC_LO = 2;
  localparam int unsigned SRC_N  = 5;
  localparam int unsigned SRC_HI = SRC_LO + SRC_N - 1;
  localparam int unsigned POR_B  = 1;
  localparam int unsigned MST_B  = 0;

  typedef enum logic [1:0] {CLR_BY_REG, CLR_BY_SER_RD, CLR_BY_SER_WR} clr_kind_e;

  // how the flag at a given read-bit position is cleared
  function automatic clr_kind_e clr_kind(int unsigned bitpos);
    case (bitpos)
      4:       return CLR_BY_SER_RD;
      5:       return CLR_BY_SER_WR;
      default: return CLR_BY_REG;
    endcase
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import split_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW-1:0]    d_i,
  output logic [SRC_N-1:0] q_o
);
  logic unused_wbits;
  assign unused_wbits = ^{d_i[DW-1:SRC_HI+1], d_i[SRC_LO-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i[SRC_HI:SRC_LO];
  end
endmodule

// File: rtl/irq_src_flag.sv
module irq_src_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import split_irq_pkg::*;
(
  input  logic [SRC_N-1:0] status_i,
  input  logic [SRC_N-1:0] enable_i,
  input  logic             por_i,
  output logic             master_o,
  output logic [DW-1:0]    rdata_o
);
  assign master_o = |(status_i & enable_i);

  always_comb begin
    rdata_o                = '0;
    rdata_o[DW-1]          = 1'b1;
    rdata_o[SRC_HI:SRC_LO] = status_i;
    rdata_o[POR_B]         = por_i;
    rdata_o[MST_B]         = master_o;
  end
endmodule

// File: rtl/split_irq_ctrl.sv
module split_irq_ctrl
  import split_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_wr_i,
  input  logic             irq_rd_i,
  input  logic             clr_wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ser_rd_i,
  input  logic             ser_wr_i,
  input  logic [SRC_N-1:0] evt_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_no
);
  logic [SRC_N-1:0] mask_q;
  logic [SRC_N-1:0] status;
  logic             por_q;
  logic             master;

  irq_enable_reg u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (irq_wr_i),
    .d_i   (wdata_i),
    .q_o   (mask_q)
  );

  for (genvar k = 0; k < SRC_N; k++) begin : g_src
    localparam int unsigned BP = SRC_LO + k;
    logic clr;
    if (clr_kind(BP) == CLR_BY_SER_RD) begin : g_rd
      assign clr = ser_rd_i;
    end else if (clr_kind(BP) == CLR_BY_SER_WR) begin : g_wr
      assign clr = ser_wr_i;
    end else begin : g_reg
      assign clr = clr_wr_i & wdata_i[BP];
    end
    irq_src_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt_i[k]),
      .clr_i (clr),
      .q_o   (status[k])
    );
  end

  // power-on flag: set by reset, dropped by first read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       por_q <= 1'b1;
    else if (irq_rd_i) por_q <= 1'b0;
  end

  irq_read_mux u_mux (
    .status_i(status),
    .enable_i(mask_q),
    .por_i   (por_q),
    .master_o(master),
    .rdata_o (rdata_o)
  );

  assign irq_no = ~master;
endmodule

// File: rtl/split_irq_ctrl_chk.sv
module split_irq_ctrl_chk
  import split_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_wr_i,
  input logic             irq_rd_i,
  input logic             clr_wr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             ser_rd_i,
  input logic             ser_wr_i,
  input logic [SRC_N-1:0] evt_i,
  input logic [DW-1:0]    rdata_o,
  input logic             irq_no,
  input logic [SRC_N-1:0] mask_q
);
  // R4
  bit7_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) rdata_o[DW-1]);
  // R4
  por_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_rd_i |=> !rdata_o[POR_B]);
  // R5
  irq_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !(|(rdata_o[SRC_HI:SRC_LO] & mask_q)));
  // R1
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !irq_wr_i |=> $stable(mask_q));
  // R6
  clr_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i && wdata_i[2] && !evt_i[0] |=> !rdata_o[2]);
  // R7
  rx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) ser_rd_i && !evt_i[2] |=> !rdata_o[4]);
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) evt_i[1] |=> rdata_o[3]);
  // R2
  tx_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) rdata_o[5] && !ser_wr_i |=> rdata_o[5]);
endmodule

bind split_irq_ctrl split_irq_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_wr_i(irq_wr_i),
  .irq_rd_i(irq_rd_i),
  .clr_wr_i(clr_wr_i),
  .wdata_i (wdata_i),
  .ser_rd_i(ser_rd_i),
  .ser_wr_i(ser_wr_i),
  .evt_i   (evt_i),
  .rdata_o (rdata_o),
  .irq_no  (irq_no),
  .mask_q  (mask_q)
);

// File: tb/split_irq_ctrl_bench.sv
module split_irq_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       irq_wr_i = 1'b0, irq_rd_i = 1'b0, clr_wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       ser_rd_i = 1'b0, ser_wr_i = 1'b0;
  logic [4:0] evt_i = '0;
  logic [7:0] rdata_o;
  logic       irq_no;
  int n_chk = 0, n_bad = 0;

  split_irq_ctrl u_split_irq_ctrl (.*);

  always #10 clk_i = ~clk_i;

  // {mask byte, event bits (low 5), expected read byte with por already 0}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'h1F, 8'hFC},
    {8'h7C, 8'h00, 8'h80},
    {8'h04, 8'h01, 8'h85},
    {8'h08, 8'h01, 8'h84},
    {8'h40, 8'h10, 8'hC1},
    {8'h7F, 8'h04, 8'h91},
    {8'h83, 8'h1F, 8'hFC},
    {8'h20, 8'h08, 8'hA1}
  };

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    irq_wr_i = 0; irq_rd_i = 0; clr_wr_i = 0; ser_rd_i = 0; ser_wr_i = 0;
    evt_i = '0; wdata_i = '0;
  endtask

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_no actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_wr_i = 1; wdata_i = 8'h4C; ser_rd_i = 1; ser_wr_i = 1;
    tick(); idle();
  endtask

  task automatic pulse_evt(input logic [4:0] e);
    evt_i = e; tick(); idle();
  endtask

  task automatic write_mask(input logic [7:0] m);
    irq_wr_i = 1; wdata_i = m; tick(); idle();
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    // R9 R4: reset state
    chk8(rdata_o, 8'h82, "R9");
    chk1(irq_no, 1'b1, "R9");
    rst_ni = 1;
    tick();
    chk8(rdata_o, 8'h82, "R4 por held");
    irq_rd_i = 1; tick(); idle();
    chk8(rdata_o, 8'h80, "R4 por cleared");

    // R1 R2 R3 R5 vector walk
    foreach (VEC[i]) begin
      write_mask(VEC[i][23:16]);
      pulse_evt(VEC[i][12:8]);
      chk8(rdata_o, VEC[i][7:0], $sformatf("R2/R3/R1 vec%0d", i));
      chk1(irq_no, ~VEC[i][0], $sformatf("R5 vec%0d", i));
      clear_all();
      chk8(rdata_o, 8'h80, $sformatf("R6/R7 cleared vec%0d", i));
    end

    // R6: clear register ignores bits 4,5
    write_mask(8'h00);
    pulse_evt(5'h1F);
    clr_wr_i = 1; wdata_i = 8'h7C; tick(); idle();
    chk8(rdata_o, 8'hB0, "R6 only 2,3,6 cleared");
    // R7: serial read clears rx, write clears tx
    ser_rd_i = 1; tick(); idle();
    chk8(rdata_o, 8'hA0, "R7 rx cleared");
    ser_wr_i = 1; tick(); idle();
    chk8(rdata_o, 8'h80, "R7 tx cleared");

    // R6: partial clear
    pulse_evt(5'h1F);
    clr_wr_i = 1; wdata_i = 8'h04; tick(); idle();
    chk8(rdata_o, 8'hF8, "R6 display only");
    clear_all();

    // R8: set wins over same-cycle clear
    evt_i = 5'h02; clr_wr_i = 1; wdata_i = 8'h08; tick(); idle();
    chk8(rdata_o, 8'h88, "R8 set wins");
    clear_all();

    // R5 R7: irq follows rx flag and drops on serial read
    write_mask(8'h10);
    pulse_evt(5'h04);
    chk1(irq_no, 1'b0, "R5 asserted");
    ser_rd_i = 1; tick(); idle();
    chk1(irq_no, 1'b1, "R5 released");

    // R9: reset mid-run drops enables
    write_mask(8'h7C);
    rst_ni = 0; tick(); rst_ni = 1; tick();
    pulse_evt(5'h01);
    chk8(rdata_o, 8'h86, "R9 masked after reset");
    chk1(irq_no, 1'b1, "R9 irq high");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule